// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer with Fractional Period Correction

This block is a 32-bit up-counter that software drives through a simple register read/write port. A power-of-two prescaler slows the count rate. When the counter passes its all-ones value it either reloads from a software-set start value or stops, and in either case it raises an overflow flag. If the overflow enable bit is set, that flag drives an interrupt line. Software sets the reload value to (all-ones minus N plus one) to get an overflow every N counting ticks.

Some periods cannot be expressed as a whole number of ticks. A 1 ms period from a 32768 Hz source is one example. For these, a signed correction accumulator is driven by two increment registers, one positive and one negative. On each overflow the accumulator decides whether the next period is lengthened by one tick. Over many periods the average then lands on the fractional target. With increments of +232000 and -768000, 768 of every 1000 periods gain a tick.

Reads are combinational and have no side effects. A write takes effect at the clock edge on which the write strobe is high.

Top module: `tmr_frac_timer`

## Requirements
- R1: After reset, every register reads zero and the interrupt output is low.
- R2: The rate at which a running counter advances is set by the prescaler bit in the control register (address 0):
  - With control bit 2 (prescaler enable) clear, the counter advances by one on every clock edge.
  - With control bit 2 set, the counter advances once every 2^(P+1) edges, where P is control bits 5:3.
  - Control bit 0 is the run bit.
  - The prescaler phase restarts whenever the counter is stopped or written.
- R3: When control bit 1 (auto-reload) is set and a tick arrives at count 0xFFFFFFFF, the counter loads the reload register (address 2) on that edge.
- R4: When auto-reload is clear and a tick arrives at count 0xFFFFFFFF, the counter becomes 0 and the run bit clears on that edge.
- R5: While the run bit is clear, the counter (address 1) holds its value.
- R6: The status register (address 3) bit 0 is the overflow flag:
  - The flag sets on the overflow edge.
  - Writing 1 to status bit 0 clears the flag.
  - If a clear and an overflow fall on the same edge, the flag stays set.
- R7: The interrupt output is high exactly when the overflow flag and interrupt-enable bit 0 (address 4) are both set.
- R8: The correction accumulator works only when both the positive increment (address 5) and the negative increment (address 6) are nonzero:
  - On each overflow, if the accumulator is negative, it adds the positive increment and the reload value is the reload register minus one, which gives one extra tick.
  - Otherwise it adds the negative increment and the reload is unchanged.
- R9: When either increment is zero, no period is lengthened. Any write to the counter resets the accumulator to zero.
- R10: The control, reload and both increment registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench times a status clear to land on the same edge as an overflow. A design in which the clear wins would lose that interrupt.

It runs correction sequences long enough that a stretched period shows up as a counter value one lower than an unstretched period would give. This catches a design that stretches on the wrong sign, always stretches, or corrects with one increment at zero.

It also writes the counter while the accumulator holds a nonzero value. A design that keeps the old accumulator would stretch the first period and end one count off.

Prescaler runs check the tick count over a fixed number of edges. A divider that is off by a power of two, or that does not restart its phase, produces a different count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_LOAD  = 3'd2,
    A_STAT  = 3'd3,
    A_IEN   = 3'd4,
    A_POS   = 3'd5,
    A_NEG   = 3'd6
  } reg_addr_e;

  // A negative accumulator takes the positive step (and lengthens the period).
  function automatic logic [DATA_W-1:0] corr_next(input logic [DATA_W-1:0] acc,
                                                  input logic [DATA_W-1:0] pos,
                                                  input logic [DATA_W-1:0] neg);
    return acc[DATA_W-1] ? acc + pos : acc + neg;
  endfunction

  // Reload value for the next period, one tick longer when stretched.
  function automatic logic [DATA_W-1:0] reload_value(input logic [DATA_W-1:0] load,
                                                     input logic stretch);
    return stretch ? load - DATA_W'(1) : load;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             clr,
  output logic             tick
);
  localparam int DIV_W = 1 << PTV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // Terminal count is 2^(ptv+1)-1: the low ptv+1 bits are set.
  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(ptv));
  end

  assign tick = run & (~pre_en | (div_q == mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               div_q <= '0;
    else if (clr || !run)     div_q <= '0;
    else if (tick)            div_q <= '0;
    else                      div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/tmr_correct.sv
module tmr_correct
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_evt,
  input  logic              clr,
  input  logic [DATA_W-1:0] pos_inc,
  input  logic [DATA_W-1:0] neg_inc,
  output logic              stretch,
  output logic [DATA_W-1:0] acc
);
  logic active;

  assign active  = (|pos_inc) & (|neg_inc);
  assign stretch = active & acc[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc <= '0;
    else if (clr)               acc <= '0;
    else if (ovf_evt && active) acc <= corr_next(acc, pos_inc, neg_inc);
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              reload_en,
  input  logic [DATA_W-1:0] load,
  input  logic              stretch,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_data,
  output logic [DATA_W-1:0] cnt,
  output logic              ovf_evt,
  output logic              stop_evt
);
  // A software write to the counter takes priority over counting.
  assign ovf_evt  = run & tick & (&cnt) & ~sw_wr;
  assign stop_evt = ovf_evt & ~reload_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (sw_wr)      cnt <= sw_data;
    else if (ovf_evt)    cnt <= reload_en ? reload_value(load, stretch) : '0;
    else if (run && tick) cnt <= cnt + DATA_W'(1);
  end
endmodule

// File: rtl/tmr_frac_timer.sv
module tmr_frac_timer
  import tmr_pkg::*;
#(
  parameter int PTV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int PTV_LSB = 3;

  logic              run, reload_en, pre_en;
  logic [PTV_W-1:0]  ptv;
  logic [DATA_W-1:0] load, pos_inc, neg_inc, cnt, acc;
  logic              ovf_flag, ien;
  logic              tick, stretch, ovf_evt, stop_evt;
  logic              ctrl_wr, cnt_wr, load_wr, stat_wr, ien_wr, pos_wr, neg_wr;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
  assign load_wr = bus_wr && (bus_addr == A_LOAD);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign ien_wr  = bus_wr && (bus_addr == A_IEN);
  assign pos_wr  = bus_wr && (bus_addr == A_POS);
  assign neg_wr  = bus_wr && (bus_addr == A_NEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; reload_en <= 1'b0; pre_en <= 1'b0; ptv <= '0;
    end else if (ctrl_wr) begin
      run       <= bus_wdata[0];
      reload_en <= bus_wdata[1];
      pre_en    <= bus_wdata[2];
      ptv       <= bus_wdata[PTV_LSB +: PTV_W];
    end else if (stop_evt) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load <= '0; pos_inc <= '0; neg_inc <= '0; ien <= 1'b0;
    end else begin
      if (load_wr) load    <= bus_wdata;
      if (pos_wr)  pos_inc <= bus_wdata;
      if (neg_wr)  neg_inc <= bus_wdata;
      if (ien_wr)  ien     <= bus_wdata[0];
    end
  end

  // Set has priority over a write-one clear on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ovf_flag <= 1'b0;
    else if (ovf_evt)                  ovf_flag <= 1'b1;
    else if (stat_wr && bus_wdata[0])  ovf_flag <= 1'b0;
  end

  assign irq_o = ovf_flag & ien;

  tmr_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_en(pre_en), .ptv(ptv),
    .clr(cnt_wr), .tick(tick)
  );

  tmr_correct u_corr (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .clr(cnt_wr),
    .pos_inc(pos_inc), .neg_inc(neg_inc), .stretch(stretch), .acc(acc)
  );

  tmr_count u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .reload_en(reload_en),
    .load(load), .stretch(stretch), .sw_wr(cnt_wr), .sw_data(bus_wdata),
    .cnt(cnt), .ovf_evt(ovf_evt), .stop_evt(stop_evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[0] = run;
        bus_rdata[1] = reload_en;
        bus_rdata[2] = pre_en;
        bus_rdata[PTV_LSB +: PTV_W] = ptv;
      end
      A_COUNT: bus_rdata = cnt;
      A_LOAD:  bus_rdata = load;
      A_STAT:  bus_rdata[0] = ovf_flag;
      A_IEN:   bus_rdata[0] = ien;
      A_POS:   bus_rdata = pos_inc;
      A_NEG:   bus_rdata = neg_inc;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_frac_timer_chk.sv
module tmr_frac_timer_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ovf_evt,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic              run,
  input logic              reload_en,
  input logic              pre_en,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] load,
  input logic [DATA_W-1:0] acc,
  input logic              ovf_flag,
  input logic              ien,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pre_en && !cnt_wr && !ovf_evt) |=> (cnt == $past(cnt) + ONE));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && reload_en) |=> (cnt == $past(load) || cnt == $past(load) - ONE));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !reload_en && !ctrl_wr) |=> (!run && cnt == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq_o);

  p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (acc == '0));
endmodule

bind tmr_frac_timer tmr_frac_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
  .run(run), .reload_en(reload_en), .pre_en(pre_en), .cnt(cnt), .load(load),
  .acc(acc), .ovf_flag(ovf_flag), .ien(ien), .irq_o(irq_o)
);

// File: tb/tmr_frac_timer_tb_top.sv
module tmr_frac_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  item_t sb_q[$];
  event smp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_frac_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Monitor: pops expected items and compares them with the port values.
  initial begin
    forever begin
      @(smp_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq_o} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input bit is_irq, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.addr = a; it.exp = e; it.is_irq = is_irq; it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
    #2;
  endtask

  localparam logic [2:0] CTRL = 3'd0, COUNT = 3'd1, LOAD = 3'd2, STAT = 3'd3,
                         IEN = 3'd4, POS = 3'd5, NEG = 3'd6;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 7; a++) chk(3'(a), 32'd0, 0, "R1 reset");
    chk(CTRL, 32'd0, 1, "R1 irq");

    // R2: undivided counting, then R5 hold while stopped
    wr(COUNT, 32'd0); wr(CTRL, 32'h1); idle(9); wr(CTRL, 32'h0);
    chk(COUNT, 32'd10, 0, "R2 no prescale");
    idle(5);
    chk(COUNT, 32'd10, 0, "R5 hold");

    // R2: divide by 4 (P=1) over 12 edges, divide by 8 (P=2) over 16 edges
    wr(COUNT, 32'd0); wr(CTRL, 32'h1 | 32'h4 | (32'd1 << 3)); idle(11); wr(CTRL, 32'h0);
    chk(COUNT, 32'd3, 0, "R2 div4");
    wr(COUNT, 32'd0); wr(CTRL, 32'h1 | 32'h4 | (32'd2 << 3)); idle(15); wr(CTRL, 32'h0);
    chk(COUNT, 32'd2, 0, "R2 div8");

    // R3 auto-reload, R6/R7 flag and interrupt
    wr(LOAD, 32'hFFFF_FFF0);
    chk(LOAD, 32'hFFFF_FFF0, 0, "R10 load readback");
    wr(COUNT, 32'hFFFF_FFFD); wr(CTRL, 32'h3); idle(4); wr(CTRL, 32'h0);
    chk(COUNT, 32'hFFFF_FFF2, 0, "R3 reload");
    chk(STAT, 32'd1, 0, "R6 flag set");
    chk(CTRL, 32'd0, 1, "R7 irq masked");
    wr(IEN, 32'd1);
    chk(CTRL, 32'd1, 1, "R7 irq enabled");
    wr(STAT, 32'd1);
    chk(STAT, 32'd0, 0, "R6 w1c");
    chk(CTRL, 32'd0, 1, "R7 irq after clear");

    // R6: clear on the overflow edge leaves the flag set
    wr(COUNT, 32'hFFFF_FFFD); wr(CTRL, 32'h3); idle(2); wr(STAT, 32'd1); wr(CTRL, 32'h0);
    chk(STAT, 32'd1, 0, "R6 set wins");
    chk(CTRL, 32'd1, 1, "R7 irq set wins");
    wr(STAT, 32'd1);

    // R4: no auto-reload stops at zero
    wr(COUNT, 32'hFFFF_FFFE); wr(CTRL, 32'h1); idle(4);
    chk(COUNT, 32'd0, 0, "R4 wrap to zero");
    chk(CTRL, 32'd0, 0, "R4 run cleared");
    chk(STAT, 32'd1, 0, "R4 flag");
    wr(STAT, 32'd1); wr(IEN, 32'd0);

    // R8: correction, 4-tick nominal period
    wr(LOAD, 32'hFFFF_FFFC);
    wr(POS, 32'd232000); wr(NEG, 32'(-768000));
    chk(POS, 32'd232000, 0, "R10 pos readback");
    chk(NEG, 32'(-768000), 0, "R10 neg readback");
    wr(COUNT, 32'hFFFF_FFFC); wr(CTRL, 32'h3); idle(12); wr(CTRL, 32'h0);
    chk(COUNT, 32'hFFFF_FFFB, 0, "R8 stretched reload");
    chk(CTRL, 32'd0, 0, "R10 ctrl readback");
    wr(CTRL, 32'h3); idle(14); wr(CTRL, 32'h0);
    chk(COUNT, 32'hFFFF_FFFC, 0, "R8 unstretched after positive acc");

    // R9: counter write clears the accumulator
    wr(COUNT, 32'hFFFF_FFFC); wr(CTRL, 32'h3); idle(7); wr(CTRL, 32'h0);
    chk(COUNT, 32'hFFFF_FFFB, 0, "R9 acc cleared by write");

    // R9: a zero increment disables correction
    wr(POS, 32'd0);
    wr(COUNT, 32'hFFFF_FFFC); wr(CTRL, 32'h3); idle(12); wr(CTRL, 32'h0);
    chk(COUNT, 32'hFFFF_FFFD, 0, "R9 inactive");

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule